// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block owns the fetch program counter of a small in-order core that uses 16-bit instruction units. Every branch form handled here has exactly one architectural delay slot. The instruction fetched right after a branch always executes, whether or not the branch is taken. Only after that instruction does the PC jump to the target.

Each cycle the decoder outside the block presents the decoded instruction at the current PC. The presented fields are:
- a branch kind;
- a 4-bit condition selector;
- a displacement field;
- the value of the addressed general register;
- the current return-pointer value;
- the N, Z, V and C flags.

When a branch issues, the block evaluates the condition and works out the target from the operand values of that cycle. It stores the outcome in one pending-target register and one pending flag. It uses that stored outcome to load the PC one fetch later. Calls produce a return-pointer write strobe in the issue cycle.

Register reads and writes stay in program order. Only the PC update is postponed. A later change to the register operand therefore cannot move a branch that has already issued. A branch placed inside a delay slot is illegal: it is reported and has no effect. A stall input freezes all sequencing state.

Top module: `dbr_pc_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `pc` equals the `RESET_PC` parameter (default 0x100). At that point `slot_active`, `rp_we` and `slot_err` are all 0.
- R2: In an unstalled cycle that starts no branch and is not a delay slot, `pc` advances by 2 at the next clock edge.
- R3: A branch issues when `br_valid` is high with a legal kind, `slot_active` is low and `stall` is low. In the next cycle `pc` is the branch address plus 2 and `slot_active` is high, whatever the condition result. `slot_active` lasts exactly one unstalled cycle.
- R4: At the clock edge that ends the delay-slot cycle, `pc` is loaded with the stored target if the branch was taken. If it was not taken, `pc` gets the branch address plus 4.
- R5: Kind 0 (conditional relative) selects its condition with `br_cond`. The codes are:
  - 0 always, 1 never;
  - 2 Z, 3 not Z;
  - 4 C, 5 not C;
  - 6 N, 7 not N;
  - 8 V, 9 not V;
  - 10 N xor V, 11 not (N xor V);
  - 12 Z or (N xor V), 13 not Z and not (N xor V);
  - 14 C or Z, 15 not C and not Z.

  All other kinds are always taken. Flags are sampled only in the issue cycle.
- R6: For kind 0 the target is the branch address + 2 + 2 × (sign-extended `br_disp[8:0]`). Bits 11:9 are ignored.
- R7: Kinds 2 (call relative, target = branch address + 2 + 2 × sign-extended `br_disp[11:0]`) and 3 (call to register) raise `rp_we` in the issue cycle. In that cycle `rp_wdata` = branch address + 4.
- R8: Kinds 1 (jump to register) and 3 take their target from `reg_val` as sampled in the issue cycle. Later values of `reg_val` do not affect it.
- R9: Kind 4 (return) takes its target from `rp_val` as sampled in the issue cycle.
- R10: A legal branch presented while `slot_active` is high, with `stall` low, raises `slot_err`. It is otherwise ignored: no `rp_we`, and no change to the pending redirect or to the following PC sequence.
- R11: While `stall` is high, `pc` and `slot_active` hold their values, and `rp_we` and `slot_err` stay low. A branch presented under stall does not issue.
- R12: Kind codes 5 to 7 are not branches: they start no delay slot and do not raise `slot_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all sequencing state |
| br_valid | input | 1 | Current instruction carries a decoded branch |
| br_kind | input | 3 | Branch kind code (R5, R7 to R9, R12) |
| br_cond | input | 4 | Condition selector for kind 0 |
| br_disp | input | 12 | Displacement field (9 or 12 bits used) |
| reg_val | input | AW | Value of the addressed general register |
| rp_val | input | AW | Current return-pointer value |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc | output | AW | Fetch address |
| slot_active | output | 1 | Current instruction is a delay slot |
| slot_err | output | 1 | Illegal branch found in a delay slot |
| rp_we | output | 1 | Return-pointer write strobe |
| rp_wdata | output | AW | Return-pointer write value |

## Verification
Two things can land in the same cycle: the deferred redirect taking effect, and a second branch arriving in the delay slot. In that cycle the PC must take the first branch's outcome, while the second branch is flagged and dropped.

The bench provokes this in two ways:
- It places a call right behind a taken branch, and checks that `slot_err` rises, `rp_we` stays low and the PC lands on the first target.
- It places a register jump behind a never-taken branch, and checks that the PC falls through by 4 and keeps counting by 2, with no trace of the rejected jump.

A stall held across the delay-slot cycle tests the same overlap. The redirect must wait until the stall is released.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    typedef enum logic [2:0] {
        BK_COND    = 3'd0,
        BK_JREG    = 3'd1,
        BK_CALLREL = 3'd2,
        BK_CALLREG = 3'd3,
        BK_RET     = 3'd4
    } br_kind_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_NEVER  = 4'd1,
        CC_EQ     = 4'd2,
        CC_NE     = 4'd3,
        CC_CS     = 4'd4,
        CC_CC     = 4'd5,
        CC_MI     = 4'd6,
        CC_PL     = 4'd7,
        CC_VS     = 4'd8,
        CC_VC     = 4'd9,
        CC_LT     = 4'd10,
        CC_GE     = 4'd11,
        CC_LE     = 4'd12,
        CC_GT     = 4'd13,
        CC_LS     = 4'd14,
        CC_HI     = 4'd15
    } cond_e;

endpackage

// File: rtl/dbr_cond_eval.sv
module dbr_cond_eval
    import dbr_pkg::*;
(
    input  logic [3:0] cond,
    input  logic       n,
    input  logic       z,
    input  logic       v,
    input  logic       c,
    output logic       taken
);

    logic lt_w;

    always_comb begin
        lt_w = n ^ v;
        unique case (cond_e'(cond))
            CC_ALWAYS: taken = 1'b1;
            CC_NEVER:  taken = 1'b0;
            CC_EQ:     taken = z;
            CC_NE:     taken = ~z;
            CC_CS:     taken = c;
            CC_CC:     taken = ~c;
            CC_MI:     taken = n;
            CC_PL:     taken = ~n;
            CC_VS:     taken = v;
            CC_VC:     taken = ~v;
            CC_LT:     taken = lt_w;
            CC_GE:     taken = ~lt_w;
            CC_LE:     taken = z | lt_w;
            CC_GT:     taken = ~z & ~lt_w;
            CC_LS:     taken = c | z;
            CC_HI:     taken = ~c & ~z;
            default:   taken = 1'b0;
        endcase
    end

    // R5: the fixed selectors ignore the flags
    always_comb begin
        if (cond == 4'd0) begin
            p_always_taken_r5: assert (taken == 1'b1);
        end
        if (cond == 4'd1) begin
            p_never_taken_r5: assert (taken == 1'b0);
        end
    end

endmodule

// File: rtl/dbr_target_gen.sv
module dbr_target_gen
    import dbr_pkg::*;
#(
    parameter int AW = 32,
    parameter int DB = 9,
    parameter int DC = 12
) (
    input  logic [AW-1:0] issue_pc,
    input  logic [2:0]    kind,
    input  logic [DC-1:0] disp,
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] rp_val,
    output logic          is_branch,
    output logic          is_call,
    output logic          is_cond,
    output logic [AW-1:0] target,
    output logic [AW-1:0] link
);

    localparam logic [AW-1:0] ISZ = AW'(2);

    logic [AW-1:0] base_w;
    logic [AW-1:0] off_b_w;
    logic [AW-1:0] off_c_w;

    assign base_w  = issue_pc + ISZ;
    assign off_b_w = {{(AW-DB){disp[DB-1]}}, disp[DB-1:0]} << 1;
    assign off_c_w = {{(AW-DC){disp[DC-1]}}, disp[DC-1:0]} << 1;
    assign link    = base_w + ISZ;

    always_comb begin
        is_branch = 1'b1;
        is_call   = 1'b0;
        is_cond   = 1'b0;
        target    = base_w;
        unique case (br_kind_e'(kind))
            BK_COND: begin
                is_cond = 1'b1;
                target  = base_w + off_b_w;
            end
            BK_JREG: begin
                target = reg_val;
            end
            BK_CALLREL: begin
                is_call = 1'b1;
                target  = base_w + off_c_w;
            end
            BK_CALLREG: begin
                is_call = 1'b1;
                target  = reg_val;
            end
            BK_RET: begin
                target = rp_val;
            end
            default: begin
                is_branch = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbr_pc_seq.sv
module dbr_pc_seq
    import dbr_pkg::*;
#(
    parameter int              AW       = 32,
    parameter int              DB       = 9,
    parameter int              DC       = 12,
    parameter logic [AW-1:0]   RESET_PC = 32'h0000_0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          br_valid,
    input  logic [2:0]    br_kind,
    input  logic [3:0]    br_cond,
    input  logic [DC-1:0] br_disp,
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] rp_val,
    input  logic          flag_n,
    input  logic          flag_z,
    input  logic          flag_v,
    input  logic          flag_c,
    output logic [AW-1:0] pc,
    output logic          slot_active,
    output logic          slot_err,
    output logic          rp_we,
    output logic [AW-1:0] rp_wdata
);

    localparam logic [AW-1:0] ISZ = AW'(2);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          slot;
        logic          take;
        logic [AW-1:0] tgt;
    } seq_t;

    seq_t st_q, st_d;

    logic          is_branch_w;
    logic          is_call_w;
    logic          is_cond_w;
    logic          cond_ok_w;
    logic [AW-1:0] target_w;
    logic [AW-1:0] link_w;
    logic          issue_w;

    dbr_cond_eval i_cond (
        .cond  (br_cond),
        .n     (flag_n),
        .z     (flag_z),
        .v     (flag_v),
        .c     (flag_c),
        .taken (cond_ok_w)
    );

    dbr_target_gen #(
        .AW (AW),
        .DB (DB),
        .DC (DC)
    ) i_tgt (
        .issue_pc  (st_q.pc),
        .kind      (br_kind),
        .disp      (br_disp),
        .reg_val   (reg_val),
        .rp_val    (rp_val),
        .is_branch (is_branch_w),
        .is_call   (is_call_w),
        .is_cond   (is_cond_w),
        .target    (target_w),
        .link      (link_w)
    );

    always_comb begin
        st_d     = st_q;
        issue_w  = br_valid && is_branch_w && !st_q.slot && !stall;
        slot_err = br_valid && is_branch_w && st_q.slot && !stall;
        rp_we    = issue_w && is_call_w;
        rp_wdata = link_w;
        if (!stall) begin
            if (st_q.slot) begin
                st_d.pc   = st_q.take ? st_q.tgt : st_q.pc + ISZ;
                st_d.slot = 1'b0;
                st_d.take = 1'b0;
            end else begin
                st_d.pc = st_q.pc + ISZ;
                if (issue_w) begin
                    st_d.slot = 1'b1;
                    st_d.take = is_cond_w ? cond_ok_w : 1'b1;
                    st_d.tgt  = target_w;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc   <= RESET_PC;
            st_q.slot <= 1'b0;
            st_q.take <= 1'b0;
            st_q.tgt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc          = st_q.pc;
    assign slot_active = st_q.slot;

    // R3: the fetch after an issued branch is the sequential slot
    p_slot_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_w |=> (pc == $past(pc) + ISZ) && slot_active);

    // R3: a delay slot lasts one unstalled cycle
    p_slot_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_active && !stall) |=> !slot_active);

    // R11: stall freezes the sequence
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc) && $stable(slot_active)));

    // R10: a rejected branch never writes the return pointer
    p_err_no_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> !rp_we);

    // R7: the link value points past the delay slot
    p_link_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rp_we |-> (rp_wdata == pc + ISZ + ISZ));

    // R11: no side outputs while stalled
    p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !rp_we && !slot_err);

endmodule

// File: tb/test_dbr_pc_seq.sv
module test_dbr_pc_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic        br_valid;
    logic [2:0]  br_kind;
    logic [3:0]  br_cond;
    logic [11:0] br_disp;
    logic [31:0] reg_val;
    logic [31:0] rp_val;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic [31:0] pc;
    logic        slot_active;
    logic        slot_err;
    logic        rp_we;
    logic [31:0] rp_wdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_pc;

    always #5 clk = ~clk;

    dbr_pc_seq i_dbr_pc_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .br_valid    (br_valid),
        .br_kind     (br_kind),
        .br_cond     (br_cond),
        .br_disp     (br_disp),
        .reg_val     (reg_val),
        .rp_val      (rp_val),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_c      (flag_c),
        .pc          (pc),
        .slot_active (slot_active),
        .slot_err    (slot_err),
        .rp_we       (rp_we),
        .rp_wdata    (rp_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        br_valid = 1'b0;
        br_kind  = 3'd0;
        br_cond  = 4'd0;
        br_disp  = 12'd0;
        stall    = 1'b0;
        {flag_n, flag_z, flag_v, flag_c} = 4'b0000;
    endtask

    // issue one branch at exp_pc and follow it through its delay slot
    task automatic do_branch(input string tag, input logic [2:0] kind, input logic [3:0] cond,
                             input logic [11:0] disp, input logic [31:0] rv, input logic [31:0] rpv,
                             input logic [3:0] nzvc, input bit exp_take,
                             input logic [31:0] exp_tgt, input bit exp_call);
        logic [31:0] a;
        a = exp_pc;
        br_valid = 1'b1;
        br_kind  = kind;
        br_cond  = cond;
        br_disp  = disp;
        reg_val  = rv;
        rp_val   = rpv;
        {flag_n, flag_z, flag_v, flag_c} = nzvc;
        #1;
        chk({tag, " R7 rp_we"}, {31'd0, rp_we}, {31'd0, exp_call});
        if (exp_call) chk({tag, " R7 rp_wdata"}, rp_wdata, a + 32'd4);
        tick();
        br_valid = 1'b0;
        reg_val  = ~rv;
        rp_val   = ~rpv;
        {flag_n, flag_z, flag_v, flag_c} = ~nzvc;
        #1;
        chk({tag, " R3 slot pc"}, pc, a + 32'd2);
        chk({tag, " R3 slot_active"}, {31'd0, slot_active}, 32'd1);
        tick();
        exp_pc = exp_take ? exp_tgt : a + 32'd4;
        chk({tag, " R4 after slot"}, pc, exp_pc);
        chk({tag, " R3 slot cleared"}, {31'd0, slot_active}, 32'd0);
    endtask

    task automatic t_reset();
        idle_inputs();
        reg_val = 32'd0;
        rp_val  = 32'd0;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pc in reset", pc, 32'h100);
        rst_n = 1'b1;
        #1;
        chk("R1 pc", pc, 32'h100);
        chk("R1 slot_active", {31'd0, slot_active}, 32'd0);
        chk("R1 rp_we", {31'd0, rp_we}, 32'd0);
        chk("R1 slot_err", {31'd0, slot_err}, 32'd0);
        exp_pc = 32'h100;
    endtask

    task automatic t_seq();
        for (int i = 0; i < 3; i++) begin
            tick();
            exp_pc = exp_pc + 32'd2;
            chk("R2 sequential", pc, exp_pc);
        end
    endtask

    task automatic t_conditions();
        do_branch("R5 always",  3'd0, 4'd0,  12'h010, 0, 0, 4'b0000, 1, exp_pc + 34, 0);
        do_branch("R5 never",   3'd0, 4'd1,  12'h010, 0, 0, 4'b1111, 0, 0, 0);
        do_branch("R5 eq t",    3'd0, 4'd2,  12'h010, 0, 0, 4'b0100, 1, exp_pc + 34, 0);
        do_branch("R5 eq n",    3'd0, 4'd2,  12'h010, 0, 0, 4'b0000, 0, 0, 0);
        do_branch("R5 ne",      3'd0, 4'd3,  12'h010, 0, 0, 4'b0000, 1, exp_pc + 34, 0);
        do_branch("R5 c",       3'd0, 4'd4,  12'h010, 0, 0, 4'b0001, 1, exp_pc + 34, 0);
        do_branch("R5 nc",      3'd0, 4'd5,  12'h010, 0, 0, 4'b0001, 0, 0, 0);
        do_branch("R5 n",       3'd0, 4'd6,  12'h010, 0, 0, 4'b1000, 1, exp_pc + 34, 0);
        do_branch("R5 p",       3'd0, 4'd7,  12'h010, 0, 0, 4'b1000, 0, 0, 0);
        do_branch("R5 v",       3'd0, 4'd8,  12'h010, 0, 0, 4'b0010, 1, exp_pc + 34, 0);
        do_branch("R5 nv",      3'd0, 4'd9,  12'h010, 0, 0, 4'b0000, 1, exp_pc + 34, 0);
        do_branch("R5 lt t",    3'd0, 4'd10, 12'h010, 0, 0, 4'b1000, 1, exp_pc + 34, 0);
        do_branch("R5 lt n",    3'd0, 4'd10, 12'h010, 0, 0, 4'b1010, 0, 0, 0);
        do_branch("R5 ge",      3'd0, 4'd11, 12'h010, 0, 0, 4'b1010, 1, exp_pc + 34, 0);
        do_branch("R5 le t",    3'd0, 4'd12, 12'h010, 0, 0, 4'b0100, 1, exp_pc + 34, 0);
        do_branch("R5 le n",    3'd0, 4'd12, 12'h010, 0, 0, 4'b0000, 0, 0, 0);
        do_branch("R5 gt t",    3'd0, 4'd13, 12'h010, 0, 0, 4'b0000, 1, exp_pc + 34, 0);
        do_branch("R5 gt n",    3'd0, 4'd13, 12'h010, 0, 0, 4'b0100, 0, 0, 0);
        do_branch("R5 ls",      3'd0, 4'd14, 12'h010, 0, 0, 4'b0001, 1, exp_pc + 34, 0);
        do_branch("R5 hi t",    3'd0, 4'd15, 12'h010, 0, 0, 4'b0000, 1, exp_pc + 34, 0);
        do_branch("R5 hi n",    3'd0, 4'd15, 12'h010, 0, 0, 4'b0001, 0, 0, 0);
    endtask

    task automatic t_relative();
        do_branch("R6 back",      3'd0, 4'd0, 12'h1F0, 0, 0, 4'b0000, 1, exp_pc + 2 - 32, 0);
        do_branch("R6 hi bits",   3'd0, 4'd0, 12'hEFF, 0, 0, 4'b0000, 1, exp_pc + 2 + 510, 0);
        do_branch("R7 call back", 3'd2, 4'd1, 12'h800, 0, 0, 4'b0000, 1, exp_pc + 2 - 4096, 1);
        do_branch("R7 call fwd",  3'd2, 4'd1, 12'h7FF, 0, 0, 4'b0000, 1, exp_pc + 2 + 4094, 1);
    endtask

    task automatic t_register();
        do_branch("R8 jreg",     3'd1, 4'd1, 12'h000, 32'h0000_4A00, 0, 4'b0000, 1, 32'h0000_4A00, 0);
        do_branch("R8 callreg",  3'd3, 4'd1, 12'h000, 32'h0000_2200, 0, 4'b0000, 1, 32'h0000_2200, 1);
        do_branch("R9 return",   3'd4, 4'd1, 12'h000, 0, 32'h0000_0300, 4'b0000, 1, 32'h0000_0300, 0);
    endtask

    task automatic t_slot_branch();
        logic [31:0] a;
        // taken branch followed by an illegal call in its slot
        a = exp_pc;
        br_valid = 1'b1; br_kind = 3'd0; br_cond = 4'd0; br_disp = 12'h010;
        tick();
        br_kind = 3'd2; br_disp = 12'h020;
        #1;
        chk("R10 slot_err", {31'd0, slot_err}, 32'd1);
        chk("R10 no rp_we", {31'd0, rp_we}, 32'd0);
        tick();
        br_valid = 1'b0;
        #1;
        chk("R10 first target kept", pc, a + 32'd34);
        chk("R10 err clears", {31'd0, slot_err}, 32'd0);
        tick();
        chk("R10 no stray redirect", pc, a + 32'd36);
        // never-taken branch followed by an illegal register jump
        a = pc;
        br_valid = 1'b1; br_kind = 3'd0; br_cond = 4'd1;
        tick();
        br_kind = 3'd1; reg_val = 32'h0000_9000;
        #1;
        chk("R10 slot_err jreg", {31'd0, slot_err}, 32'd1);
        tick();
        br_valid = 1'b0;
        #1;
        chk("R10 fall through", pc, a + 32'd4);
        tick();
        chk("R10 keeps counting", pc, a + 32'd6);
        exp_pc = a + 32'd6;
    endtask

    task automatic t_stall();
        logic [31:0] a;
        a = exp_pc;
        stall = 1'b1;
        br_valid = 1'b1; br_kind = 3'd3; reg_val = 32'h0000_5000;
        #1;
        chk("R11 no rp_we in stall", {31'd0, rp_we}, 32'd0);
        tick();
        chk("R11 pc held", pc, a);
        chk("R11 no issue", {31'd0, slot_active}, 32'd0);
        stall = 1'b0;
        #1;
        chk("R11 issue after release", {31'd0, rp_we}, 32'd1);
        tick();
        br_valid = 1'b0;
        reg_val  = 32'h0000_7000;
        stall    = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R11 slot pc held", pc, a + 32'd2);
            chk("R11 slot held", {31'd0, slot_active}, 32'd1);
        end
        stall = 1'b0;
        tick();
        chk("R11 redirect after stall", pc, 32'h0000_5000);
        exp_pc = 32'h0000_5000;
    endtask

    task automatic t_bad_kind();
        logic [31:0] a;
        for (int k = 5; k < 8; k++) begin
            a = exp_pc;
            br_valid = 1'b1; br_kind = 3'(k);
            #1;
            chk("R12 no rp_we", {31'd0, rp_we}, 32'd0);
            tick();
            br_valid = 1'b0;
            #1;
            chk("R12 no slot", {31'd0, slot_active}, 32'd0);
            chk("R12 sequential", pc, a + 32'd2);
            exp_pc = a + 32'd2;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_seq();
        t_conditions();
        t_relative();
        t_register();
        t_slot_branch();
        t_stall();
        t_bad_kind();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule